// File: doc/BRIEF.md
# Three-Dimensional Lane Tuple Sequencer

This block walks a three-level index space. It produces one lane tuple (lc0, lc1, lc2) for each replay of a block body. Three 16-bit bounds set the extent of the walk. A block header loads them through a dedicated write port, and they can also be reached through a small special-register bus. That bus also exposes the three counters.

A start pulse clears the counters and opens the walk. The sequencer holds each tuple with `tuple_valid_o` high until the body signals completion on `body_done_i`. It then steps to the next tuple. lc0 moves fastest and lc2 slowest. `last_o` marks the final tuple. Completion of that tuple raises `done_o`, which stays high until the next start. A zero bound on either outer dimension counts as a bound of one. A zero innermost bound means the walk is empty.

Top module: `lane_tuple_seq`

## Requirements
- R1: After reset, all counters and all bounds read 0, and `tuple_valid_o`, `last_o` and `done_o` are low.
- R2: A start while not running clears all three counters. With a nonzero innermost bound, `tuple_valid_o` is high in the next cycle with tuple (0,0,0) and `done_o` is low.
- R3: Each `body_done_i` while valid steps lc0 by one. When lc0 is at bound0-1 it returns to 0 and lc1 steps. When lc1 is at its limit it returns to 0 and lc2 steps.
- R4: A bound of 0 on dimension 1 or 2 behaves exactly like a bound of 1.
- R5: While valid and without `body_done_i`, the tuple and `tuple_valid_o` hold.
- R6: `last_o` is high exactly while valid on the tuple (bound0-1, max(bound1,1)-1, max(bound2,1)-1).
- R7: `body_done_i` on the final tuple drops `tuple_valid_o` and raises `done_o` in the next cycle. `done_o` stays high until the next start, and the counters keep the final tuple.
- R8: A start with bound0 = 0 issues no tuple, and `done_o` is high in the cycle after the start.
- R9: A run presents exactly bound0·max(bound1,1)·max(bound2,1) tuples, each once, in the order of R3.
- R10: The special-register map is: address 0x050+d holds bound d and address 0x053+d holds counter d, for d = 0..2. `sr_rdata_o` returns the addressed register combinationally. Any other address reads 0. A write through this bus loads the addressed bound.
- R11: `hdr_we_i` loads bound `hdr_sel_i` (0..2) from `hdr_data_i`. If it hits the same bound in the same cycle as a bus write, the header write wins.
- R12: While running, bound writes from either port, counter writes from the bus, and start are all ignored.
- R13: A bus write to a counter while not running loads that value directly onto the counter output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hdr_we_i | input | 1 | Header bound write strobe |
| hdr_sel_i | input | 2 | Bound index for header write |
| hdr_data_i | input | 16 | Header bound value |
| sr_addr_i | input | 12 | Special-register address |
| sr_we_i | input | 1 | Special-register write strobe |
| sr_wdata_i | input | 16 | Special-register write data |
| sr_rdata_o | output | 16 | Special-register read data |
| start_i | input | 1 | Begin a walk |
| body_done_i | input | 1 | Body finished current tuple |
| lc0_o | output | 16 | Innermost counter |
| lc1_o | output | 16 | Middle counter |
| lc2_o | output | 16 | Outermost counter |
| tuple_valid_o | output | 1 | Current tuple is live |
| last_o | output | 1 | Current tuple is the final one |
| done_o | output | 1 | Walk complete |

## Verification
The bench targets the following corner cases:
- **Carry between dimensions.** A design that carried on the wrong counter would produce tuples out of order or repeat a tuple.
- **Zero outer bounds.** A design that took these literally would wrap at 0xFFFF and never finish.
- **Zero innermost bound.** A design that mishandled it would issue a spurious tuple.
- **Collisions on the bounds.** These include a header write and a bus write to the same bound in one cycle, and bus or header writes or a restart during a run. A sequencer that accepted them would corrupt its limits mid-walk or restart.
- **Held tuple.** Random gaps before each `body_done_i` expose any design that steps without the handshake.

// File: rtl/lts_pkg.sv
package lts_pkg;
  localparam int unsigned LTS_DIMS  = 3;
  localparam int unsigned LTS_SEL_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } lts_state_e;
endpackage

// File: rtl/lts_lane_ctr.sv
module lts_lane_ctr #(
  parameter int unsigned CNT_W       = 16,
  parameter bit          ZERO_AS_ONE = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] bound_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  generate
    if (ZERO_AS_ONE) begin : g_clamp
      assign limit = (bound_i == '0) ? '0 : bound_i - CNT_W'(1);
    end else begin : g_raw
      assign limit = bound_i - CNT_W'(1);
    end
  endgenerate

  assign wrap_o = (cnt_q == limit);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (step_i) cnt_q <= wrap_o ? '0 : cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/lts_bound_regs.sv
module lts_bound_regs
  import lts_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            lock_i,
  input  logic                            hdr_we_i,
  input  logic [LTS_SEL_W-1:0]            hdr_sel_i,
  input  logic [CNT_W-1:0]                hdr_data_i,
  input  logic [LTS_DIMS-1:0]             sr_we_i,
  input  logic [CNT_W-1:0]                sr_wdata_i,
  output logic [LTS_DIMS-1:0][CNT_W-1:0]  bound_o
);
  for (genvar d = 0; d < LTS_DIMS; d++) begin : g_bnd
    logic hdr_hit;
    assign hdr_hit = hdr_we_i && (hdr_sel_i == LTS_SEL_W'(d));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bound_o[d] <= '0;
      else if (!lock_i) begin
        if (hdr_hit)        bound_o[d] <= hdr_data_i;   // header has priority
        else if (sr_we_i[d]) bound_o[d] <= sr_wdata_i;
      end
    end
  end
endmodule

// File: rtl/lts_sr_port.sv
module lts_sr_port
  import lts_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned SR_BASE = 32'h50
) (
  input  logic [ADDR_W-1:0]               sr_addr_i,
  input  logic                            sr_we_i,
  input  logic [LTS_DIMS-1:0][CNT_W-1:0]  bound_i,
  input  logic [LTS_DIMS-1:0][CNT_W-1:0]  count_i,
  output logic [LTS_DIMS-1:0]             bnd_we_o,
  output logic [LTS_DIMS-1:0]             cnt_we_o,
  output logic [CNT_W-1:0]                rdata_o
);
  localparam logic [ADDR_W-1:0] BND_A = ADDR_W'(SR_BASE);
  localparam logic [ADDR_W-1:0] CNT_A = ADDR_W'(SR_BASE + LTS_DIMS);

  logic [LTS_DIMS-1:0] bnd_hit, cnt_hit;

  for (genvar d = 0; d < LTS_DIMS; d++) begin : g_dec
    assign bnd_hit[d]  = (sr_addr_i == BND_A + ADDR_W'(d));
    assign cnt_hit[d]  = (sr_addr_i == CNT_A + ADDR_W'(d));
    assign bnd_we_o[d] = sr_we_i && bnd_hit[d];
    assign cnt_we_o[d] = sr_we_i && cnt_hit[d];
  end

  always_comb begin
    rdata_o = '0;
    for (int d = 0; d < LTS_DIMS; d++) begin
      if (bnd_hit[d]) rdata_o = bound_i[d];
      if (cnt_hit[d]) rdata_o = count_i[d];
    end
  end
endmodule

// File: rtl/lts_ctrl.sv
module lts_ctrl
  import lts_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic body_done_i,
  input  logic empty_i,
  input  logic final_i,
  output logic run_o,
  output logic done_o,
  output logic clr_o,
  output logic step_o
);
  lts_state_e state_q, state_d;

  assign run_o  = (state_q == ST_RUN);
  assign done_o = (state_q == ST_DONE);
  assign clr_o  = start_i && !run_o;
  assign step_o = run_o && body_done_i && !final_i;

  always_comb begin
    state_d = state_q;
    if (clr_o)                             state_d = empty_i ? ST_DONE : ST_RUN;
    else if (run_o && body_done_i && final_i) state_d = ST_DONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/lane_tuple_seq.sv
module lane_tuple_seq
  import lts_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned SR_BASE = 32'h50
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 hdr_we_i,
  input  logic [LTS_SEL_W-1:0] hdr_sel_i,
  input  logic [CNT_W-1:0]     hdr_data_i,
  input  logic [ADDR_W-1:0]    sr_addr_i,
  input  logic                 sr_we_i,
  input  logic [CNT_W-1:0]     sr_wdata_i,
  output logic [CNT_W-1:0]     sr_rdata_o,
  input  logic                 start_i,
  input  logic                 body_done_i,
  output logic [CNT_W-1:0]     lc0_o,
  output logic [CNT_W-1:0]     lc1_o,
  output logic [CNT_W-1:0]     lc2_o,
  output logic                 tuple_valid_o,
  output logic                 last_o,
  output logic                 done_o
);
  logic [LTS_DIMS-1:0][CNT_W-1:0] bound_q;
  logic [LTS_DIMS-1:0][CNT_W-1:0] count_q;
  logic [LTS_DIMS-1:0]            bnd_we, cnt_we, step_v, wrap_v;
  logic run, clr, adv, final_tuple;

  lts_sr_port #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .SR_BASE(SR_BASE)) i_sr_port (
    .sr_addr_i (sr_addr_i),
    .sr_we_i   (sr_we_i),
    .bound_i   (bound_q),
    .count_i   (count_q),
    .bnd_we_o  (bnd_we),
    .cnt_we_o  (cnt_we),
    .rdata_o   (sr_rdata_o)
  );

  lts_bound_regs #(.CNT_W(CNT_W)) i_bounds (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lock_i     (run),
    .hdr_we_i   (hdr_we_i),
    .hdr_sel_i  (hdr_sel_i),
    .hdr_data_i (hdr_data_i),
    .sr_we_i    (bnd_we),
    .sr_wdata_i (sr_wdata_i),
    .bound_o    (bound_q)
  );

  for (genvar d = 0; d < LTS_DIMS; d++) begin : g_ctr
    if (d == 0) begin : g_inner
      assign step_v[d] = adv;
    end else begin : g_outer
      assign step_v[d] = step_v[d-1] && wrap_v[d-1];
    end

    lts_lane_ctr #(.CNT_W(CNT_W), .ZERO_AS_ONE(d != 0)) i_ctr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (clr),
      .step_i     (step_v[d]),
      .load_i     (cnt_we[d] && !run),
      .load_val_i (sr_wdata_i),
      .bound_i    (bound_q[d]),
      .cnt_o      (count_q[d]),
      .wrap_o     (wrap_v[d])
    );
  end

  assign final_tuple = &wrap_v;

  lts_ctrl i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .body_done_i (body_done_i),
    .empty_i     (bound_q[0] == '0),
    .final_i     (final_tuple),
    .run_o       (run),
    .done_o      (done_o),
    .clr_o       (clr),
    .step_o      (adv)
  );

  assign lc0_o         = count_q[0];
  assign lc1_o         = count_q[1];
  assign lc2_o         = count_q[2];
  assign tuple_valid_o = run;
  assign last_o        = run && final_tuple;
endmodule

// File: rtl/lts_checker.sv
module lts_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  start_i,
  input logic                  body_done_i,
  input logic                  tuple_valid_o,
  input logic                  last_o,
  input logic                  done_o,
  input logic [CNT_W-1:0]      lc0_o,
  input logic [CNT_W-1:0]      lc1_o,
  input logic [CNT_W-1:0]      lc2_o,
  input logic [2:0][CNT_W-1:0] bound_i
);
  a_r7_valid_done_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tuple_valid_o && done_o));

  a_r5_hold_tuple: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tuple_valid_o && !body_done_i |=> tuple_valid_o && $stable(lc0_o) && $stable(lc1_o) && $stable(lc2_o));

  a_r2_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tuple_valid_o && start_i |=> lc0_o == '0 && lc1_o == '0 && lc2_o == '0);

  a_r8_empty_walk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tuple_valid_o && start_i && bound_i[0] == '0 |=> done_o && !tuple_valid_o);

  a_r7_final_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tuple_valid_o && body_done_i && last_o |=> done_o && $stable(lc0_o) && $stable(lc1_o) && $stable(lc2_o));

  a_r3_inner_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tuple_valid_o && body_done_i && lc0_o != bound_i[0] - CNT_W'(1)
      |=> tuple_valid_o && lc0_o == $past(lc0_o) + CNT_W'(1) && $stable(lc1_o) && $stable(lc2_o));

  a_r6_last_inner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> tuple_valid_o && lc0_o == bound_i[0] - CNT_W'(1));

  a_r12_bounds_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tuple_valid_o |=> $stable(bound_i));
endmodule

bind lane_tuple_seq lts_checker #(.CNT_W(CNT_W)) i_lts_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .body_done_i   (body_done_i),
  .tuple_valid_o (tuple_valid_o),
  .last_o        (last_o),
  .done_o        (done_o),
  .lc0_o         (lc0_o),
  .lc1_o         (lc1_o),
  .lc2_o         (lc2_o),
  .bound_i       (bound_q)
);

// File: tb/test_lane_tuple_seq.sv
module test_lane_tuple_seq;
  localparam int CW = 16;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          hdr_we = 1'b0;
  logic [1:0]    hdr_sel = '0;
  logic [CW-1:0] hdr_data = '0;
  logic [AW-1:0] sr_addr = '0;
  logic          sr_we = 1'b0;
  logic [CW-1:0] sr_wdata = '0;
  logic [CW-1:0] sr_rdata;
  logic          start = 1'b0;
  logic          body_done = 1'b0;
  logic [CW-1:0] lc0, lc1, lc2;
  logic          valid, last, done;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  lane_tuple_seq i_lane_tuple_seq (
    .clk_i(clk), .rst_ni(rst_ni),
    .hdr_we_i(hdr_we), .hdr_sel_i(hdr_sel), .hdr_data_i(hdr_data),
    .sr_addr_i(sr_addr), .sr_we_i(sr_we), .sr_wdata_i(sr_wdata), .sr_rdata_o(sr_rdata),
    .start_i(start), .body_done_i(body_done),
    .lc0_o(lc0), .lc1_o(lc1), .lc2_o(lc2),
    .tuple_valid_o(valid), .last_o(last), .done_o(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int eff(input int b);
    return (b == 0) ? 1 : b;
  endfunction

  task automatic sr_wr(input int a, input int d);
    @(negedge clk); sr_we = 1'b1; sr_addr = AW'(a); sr_wdata = CW'(d);
    @(negedge clk); sr_we = 1'b0;
  endtask

  task automatic sr_rd(input int a, output int d);
    sr_addr = AW'(a); #1; d = int'(sr_rdata);
  endtask

  task automatic hdr_wr(input int s, input int d);
    @(negedge clk); hdr_we = 1'b1; hdr_sel = 2'(s); hdr_data = CW'(d);
    @(negedge clk); hdr_we = 1'b0;
  endtask

  task automatic do_start;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic pulse_done;
    @(negedge clk); body_done = 1'b1;
    @(negedge clk); body_done = 1'b0;
  endtask

  // golden walk: lc0 fastest, outer zero bounds count as one
  task automatic run_walk(input int b0, input int b1, input int b2, input bit via_hdr);
    int n;
    if (via_hdr) begin hdr_wr(0, b0); hdr_wr(1, b1); hdr_wr(2, b2); end
    else begin sr_wr('h50, b0); sr_wr('h51, b1); sr_wr('h52, b2); end
    do_start();
    if (b0 == 0) begin
      chk("R8 done after empty start", 32'(done), 1);
      chk("R8 no tuple", 32'(valid), 0);
      return;
    end
    n = 0;
    for (int z = 0; z < eff(b2); z++)
      for (int y = 0; y < eff(b1); y++)
        for (int x = 0; x < eff(b0); x++) begin
          int g;
          bit fin;
          fin = (x == b0 - 1) && (y == eff(b1) - 1) && (z == eff(b2) - 1);
          chk("R2 R9 valid", 32'(valid), 1);
          chk("R3 lc0", 32'(lc0), 32'(x));
          if (b1 == 0) chk("R4 lc1 zero bound", 32'(lc1), 32'(y));
          else         chk("R3 lc1", 32'(lc1), 32'(y));
          if (b2 == 0) chk("R4 lc2 zero bound", 32'(lc2), 32'(z));
          else         chk("R3 lc2", 32'(lc2), 32'(z));
          chk("R6 last", 32'(last), 32'(fin));
          chk("R7 no early done", 32'(done), 0);
          g = $urandom_range(0, 2);
          repeat (g) begin
            @(negedge clk);
            chk("R5 hold lc0", 32'(lc0), 32'(x));
            chk("R5 hold valid", 32'(valid), 1);
          end
          pulse_done();
          n++;
        end
    chk("R9 tuple count", 32'(n), 32'(b0 * eff(b1) * eff(b2)));
    chk("R7 done", 32'(done), 1);
    chk("R7 valid low", 32'(valid), 0);
    chk("R7 final lc0 kept", 32'(lc0), 32'(b0 - 1));
    chk("R7 final lc2 kept", 32'(lc2), 32'(eff(b2) - 1));
    @(negedge clk);
    chk("R7 done sticky", 32'(done), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int rd;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 lc0", 32'(lc0), 0);
    chk("R1 lc2", 32'(lc2), 0);
    chk("R1 valid", 32'(valid), 0);
    chk("R1 last", 32'(last), 0);
    chk("R1 done", 32'(done), 0);
    sr_rd('h51, rd); chk("R1 bound1", 32'(rd), 0);

    // R10 register map
    sr_wr('h50, 'h0011); sr_wr('h51, 'h0022); sr_wr('h52, 'h0033);
    sr_rd('h50, rd); chk("R10 bound0 read", 32'(rd), 'h11);
    sr_rd('h51, rd); chk("R10 bound1 read", 32'(rd), 'h22);
    sr_rd('h52, rd); chk("R10 bound2 read", 32'(rd), 'h33);
    sr_rd('h56, rd); chk("R10 unmapped", 32'(rd), 0);
    sr_rd('h4F, rd); chk("R10 unmapped low", 32'(rd), 0);

    // R13 counter load while idle
    sr_wr('h53, 'h1234);
    chk("R13 lc0 loaded", 32'(lc0), 'h1234);
    sr_wr('h55, 'h00AB);
    sr_rd('h55, rd); chk("R13 R10 counter2 read", 32'(rd), 'hAB);
    chk("R13 lc2 loaded", 32'(lc2), 'hAB);

    // R11 collision: header beats bus
    @(negedge clk);
    hdr_we = 1'b1; hdr_sel = 2'd1; hdr_data = 'h0AAA;
    sr_we = 1'b1; sr_addr = 'h51; sr_wdata = 'h0BBB;
    @(negedge clk);
    hdr_we = 1'b0; sr_we = 1'b0;
    sr_rd('h51, rd); chk("R11 header wins", 32'(rd), 'hAAA);
    hdr_wr(3, 'h0777);
    sr_rd('h50, rd); chk("R11 sel3 ignored", 32'(rd), 'h11);

    // directed walks
    run_walk(3, 2, 2, 1'b1);
    run_walk(1, 1, 1, 1'b0);
    run_walk(2, 0, 0, 1'b1);
    run_walk(0, 3, 3, 1'b0);
    run_walk(4, 1, 0, 1'b1);
    run_walk(1, 0, 3, 1'b0);

    // R12 writes and restart ignored while running
    hdr_wr(0, 2); hdr_wr(1, 2); hdr_wr(2, 1);
    do_start();
    pulse_done();
    chk("R12 setup lc0", 32'(lc0), 1);
    sr_wr('h50, 7);
    hdr_wr(1, 9);
    sr_wr('h53, 5);
    do_start();
    chk("R12 counter write ignored", 32'(lc0), 1);
    chk("R12 still valid", 32'(valid), 1);
    sr_rd('h50, rd); chk("R12 bus bound write ignored", 32'(rd), 2);
    sr_rd('h51, rd); chk("R12 header bound write ignored", 32'(rd), 2);
    repeat (3) pulse_done();
    chk("R12 walk completes", 32'(done), 1);

    // random walks
    for (int i = 0; i < 25; i++)
      run_walk($urandom_range(0, 5), $urandom_range(0, 4), $urandom_range(0, 3), 1'($urandom_range(0, 1)));

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule